// File: doc/BRIEF.md
# Symmetric INT8 Tensor Quantizer

The block accepts a finite tensor of signed Q16.16 fixed-point samples on a valid/ready stream and writes each sample into an internal store while it tracks the largest magnitude. When the end-of-tensor marker arrives, it derives one scale for the whole tensor from that peak. It then reads the samples back from the store in arrival order. Each sample becomes a signed 8-bit code, which is the sample divided by the scale, rounded and saturated. The codes leave on a second valid/ready stream that carries its own first and last markers. The scale stays available on a side output, so a consumer can rebuild an approximate value as code times scale.

A single state machine controls the block. Its states and transitions are:

- GATHER: accepts input samples. An accepted sample with the end marker moves the machine to SCALE and starts the divider.
- SCALE: waits for the divider. When the divider finishes, the machine moves to FETCH.
- FETCH: reads one stored sample, starts the per-element division, and moves to DIVIDE in the next cycle.
- DIVIDE: waits for the divider. When it finishes, the machine moves to PRESENT.
- PRESENT: offers the code on the output. An accepted code moves the machine back to FETCH. The accepted code that is last in the tensor moves it to GATHER instead and pulses done.

One divider is shared. Each division takes 34 cycles plus a short overhead.

Top module: `int8_tensor_quantizer`

## Requirements
- R1: After reset, and again after each finished tensor, the block is in the gathering state. In that state in_ready is high, out_valid is low, done is low and scale_out is 1. An accepted sample that carries in_eot ends gathering.
- R2: scale_out, a raw Q16.16 value, equals floor(peak / 127), where peak is the largest magnitude in the tensor. A result of 0, as for an all-zero tensor, is raised to 1, the smallest positive Q16.16 step.
- R3: When the peak is formed, the magnitude of input code 0x80000000 is saturated to 0x7FFFFFFF.
- R4: Each out_q is a two's-complement 8-bit value. Its magnitude is floor((2·|x| + scale) / (2·scale)), which rounds halves away from zero, limited to 127. Its sign is the sign of x. The code 0x80 (-128) never appears.
- R5: Codes leave in the order the samples arrived. out_sot is high on the first code only, and out_eot is high on the last code only.
- R6: From the accepted end-of-tensor sample until the last code is accepted, in_ready stays low and no input is taken.
- R7: done is high for exactly one cycle. That cycle directly follows the clock edge on which the last code is accepted.
- R8: While out_valid is high and out_ready is low, out_valid, out_q and out_eot hold their values.
- R9: A sample accepted with in_sot during gathering discards all samples gathered before it, and their magnitudes, and becomes element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block accepts a sample (gathering state) |
| in_data | input | 32 | Sample, signed Q16.16 |
| in_sot | input | 1 | Sample is the first of a tensor |
| in_eot | input | 1 | Sample is the last of a tensor |
| out_valid | output | 1 | Quantized code is valid |
| out_ready | input | 1 | Consumer accepts the code |
| out_q | output | 8 | Signed 8-bit code |
| out_sot | output | 1 | Code is the first of the tensor |
| out_eot | output | 1 | Code is the last of the tensor |
| scale_out | output | 32 | Tensor scale, Q16.16 |
| done | output | 1 | One-cycle pulse after the last code is accepted |

## Verification
The bench goes after the corners where the arithmetic is easy to get wrong:
- An all-zero tensor checks the scale floor. A design without the floor would divide by zero and emit garbage codes.
- Samples that land exactly on a half check half-away rounding. Truncating gives 1 instead of 2; rounding to even gives 0 instead of 1.
- A sample of 0x80000000 checks magnitude saturation. Without it, the peak would wrap to a huge unsigned value or become negative.
- Tensors whose peak exceeds 127 times the scale check the ±127 clip. A design that got this wrong would emit -128 or wrap.

The bench also stalls the consumer periodically and checks that the code holds, and that done pulses once. It sends an in_sot part-way through a tensor and checks that the earlier samples no longer raise the scale.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
    localparam int Q_LIMIT = 127;

    typedef enum logic [2:0] {
        ST_GATHER  = 3'd0,
        ST_SCALE   = 3'd1,
        ST_FETCH   = 3'd2,
        ST_DIVIDE  = 3'd3,
        ST_PRESENT = 3'd4
    } qnt_state_e;
endpackage

// File: rtl/qnt_abs.sv
module qnt_abs #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (!value[W-1])
            mag = value;
        else if (value == MOST_NEG)
            mag = MOST_POS;
        else
            mag = ~value + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/qnt_store.sv
module qnt_store #(
    parameter int W     = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qnt_divider.sv
module qnt_divider #(
    parameter int NUM_W = 34,
    parameter int DEN_W = 33,
    localparam int CW   = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             fin
);
    logic [DEN_W-1:0] rem, den_r;
    logic [CW-1:0]    cnt;
    logic             busy;
    logic [DEN_W:0]   shifted, diff;
    logic             fits;

    always_comb begin
        shifted = {rem, quo[NUM_W-1]};
        diff    = shifted - {1'b0, den_r};
        fits    = shifted >= {1'b0, den_r};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_r <= '0;
            quo   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                rem   <= '0;
                den_r <= den;
                quo   <= num;
                cnt   <= CW'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/int8_tensor_quantizer.sv
module int8_tensor_quantizer
    import qnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sot,
    input  logic              in_eot,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_q,
    output logic              out_sot,
    output logic              out_eot,
    output logic [DATA_W-1:0] scale_out,
    output logic              done
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;
    localparam int NUM_W = DATA_W + 2;
    localparam int DEN_W = DATA_W + 1;

    qnt_state_e st, st_nx;

    logic [AW-1:0]     wr_idx, rd_idx, wr_at;
    logic [LW-1:0]     len;
    logic [DATA_W-1:0] peak, peak_nx, scale, in_mag, rd_mag, rd_data;
    logic              neg_r, take, last;
    logic              div_start, div_fin;
    logic [NUM_W-1:0]  div_num, div_q;
    logic [DEN_W-1:0]  div_den;
    logic [7:0]        clip;

    qnt_abs #(.W(DATA_W)) u_abs_in (.value(in_data), .mag(in_mag));
    qnt_abs #(.W(DATA_W)) u_abs_rd (.value(rd_data), .mag(rd_mag));

    qnt_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (take),
        .waddr (wr_at),
        .wdata (in_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    qnt_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_q),
        .fin   (div_fin)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_GATHER;
        else
            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_GATHER:  if (take && in_eot) st_nx = ST_SCALE;
            ST_SCALE:   if (div_fin) st_nx = ST_FETCH;
            ST_FETCH:   st_nx = ST_DIVIDE;
            ST_DIVIDE:  if (div_fin) st_nx = ST_PRESENT;
            ST_PRESENT: if (out_ready) st_nx = last ? ST_GATHER : ST_FETCH;
            default:    st_nx = ST_GATHER;
        endcase
    end

    // outputs and combinational datapath
    always_comb begin
        in_ready  = (st == ST_GATHER);
        out_valid = (st == ST_PRESENT);
        take      = in_valid && in_ready;
        last      = (LW'(rd_idx) + LW'(1)) == len;
        out_sot   = out_valid && (rd_idx == '0);
        out_eot   = out_valid && last;
        scale_out = scale;
        wr_at     = in_sot ? '0 : wr_idx;
        if (in_sot || wr_idx == '0)
            peak_nx = in_mag;
        else
            peak_nx = (in_mag > peak) ? in_mag : peak;
        div_start = (st == ST_GATHER && take && in_eot) || (st == ST_FETCH);
        if (st == ST_GATHER) begin
            div_num = NUM_W'(peak_nx);
            div_den = DEN_W'(Q_LIMIT);
        end else begin
            div_num = {1'b0, rd_mag, 1'b0} + NUM_W'(scale);
            div_den = {scale, 1'b0};
        end
        clip = (div_q > NUM_W'(Q_LIMIT)) ? 8'(Q_LIMIT) : div_q[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            len    <= '0;
            peak   <= '0;
            scale  <= DATA_W'(1);
            neg_r  <= 1'b0;
            out_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_GATHER: if (take) begin
                    wr_idx <= wr_at + AW'(1);
                    peak   <= peak_nx;
                    if (in_eot)
                        len <= LW'(wr_at) + LW'(1);
                end
                ST_SCALE: if (div_fin) begin
                    scale  <= (div_q == '0) ? DATA_W'(1) : div_q[DATA_W-1:0];
                    rd_idx <= '0;
                end
                ST_FETCH: neg_r <= rd_data[DATA_W-1];
                ST_DIVIDE: if (div_fin)
                    out_q <= neg_r ? (~clip + 8'd1) : clip;
                ST_PRESENT: if (out_ready) begin
                    if (last) begin
                        done   <= 1'b1;
                        wr_idx <= '0;
                        scale  <= DATA_W'(1);
                    end else begin
                        rd_idx <= rd_idx + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assert_no_minus128_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_q != 8'h80);
    assert_scale_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scale_out != '0);
    assert_peak_saturated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !peak[DATA_W-1]);
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_q) && $stable(out_eot)));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/int8_tensor_quantizer_bench.sv
module int8_tensor_quantizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sot = 1'b0, in_eot = 1'b0, out_ready = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, out_valid, out_sot, out_eot, done;
    logic [7:0]  out_q;
    logic [31:0] scale_out;

    int total = 0;
    int bad   = 0;
    longint tv [16];
    int n = 0;

    always #5 clk = ~clk;

    int8_tensor_quantizer u_int8_tensor_quantizer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sot(in_sot), .in_eot(in_eot),
        .out_valid(out_valid), .out_ready(out_ready), .out_q(out_q),
        .out_sot(out_sot), .out_eot(out_eot),
        .scale_out(scale_out), .done(done)
    );

    // value, last-of-tensor flag
    localparam logic [32:0] TBL [18] = '{
        {32'h0001_0000, 1'b0}, {32'hFFFE_0000, 1'b0}, {32'h0000_8000, 1'b0}, {32'h0003_4000, 1'b1},
        {32'h0000_0000, 1'b0}, {32'h0000_0000, 1'b0}, {32'h0000_0000, 1'b1},
        {32'h8000_0000, 1'b0}, {32'h7FFF_FFFF, 1'b0}, {32'h0000_1234, 1'b1},
        {32'd100,       1'b0}, {-32'sd300,     1'b0}, {32'd254,       1'b1},
        {32'd254,       1'b0}, {32'd3,         1'b0}, {-32'sd3,       1'b0}, {32'd1, 1'b1},
        {-32'sd7,       1'b1}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint mag_of(input longint x);
        longint a = (x < 0) ? -x : x;
        if (a > 64'sd2147483647) a = 64'sd2147483647;
        return a;
    endfunction

    function automatic longint exp_scale();
        longint pk = 0;
        for (int i = 0; i < n; i++)
            if (mag_of(tv[i]) > pk) pk = mag_of(tv[i]);
        return (pk / 127 == 0) ? 1 : pk / 127;
    endfunction

    function automatic longint exp_q(input longint x, input longint s);
        longint q = (2 * mag_of(x) + s) / (2 * s);
        if (q > 127) q = 127;
        return (x < 0) ? -q : q;
    endfunction

    task automatic send(input logic [31:0] v, input bit sot, input bit eot);
        @(negedge clk);
        in_valid = 1'b1; in_data = v; in_sot = sot; in_eot = eot;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sot = 1'b0; in_eot = 1'b0;
    endtask

    task automatic run_out();
        longint s = exp_scale();
        int idx = 0, cyc = 0;
        bit first = 1'b1, stalled = 1'b0;
        logic [7:0] held = '0;
        chk(in_ready == 1'b0, "R6 in_ready after eot", in_ready, 0);
        while (idx < n) begin
            out_ready = (cyc % 3 != 2);
            cyc++;
            if (out_valid) begin
                if (first) chk(scale_out == s[31:0], "R2 scale", scale_out, s);
                first = 1'b0;
                chk(in_ready == 1'b0, "R6 in_ready while emitting", in_ready, 0);
                if (stalled) chk(out_q == held, "R8 held code", out_q, held);
                if (out_ready) begin
                    chk($signed(out_q) == exp_q(tv[idx], s), "R4 code", $signed(out_q), exp_q(tv[idx], s));
                    chk(out_sot == (idx == 0), "R5 out_sot", out_sot, idx == 0);
                    chk(out_eot == (idx == n - 1), "R5 out_eot", out_eot, idx == n - 1);
                    idx++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    held = out_q;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(done == 1'b1, "R7 done high", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(in_ready == 1'b1, "R1 back to gathering", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid idle", out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(scale_out == 32'd1, "R1 reset scale", scale_out, 1);

        // table walk: includes the R3 most-negative code and the R2 zero tensor
        n = 0;
        for (int i = 0; i < 18; i++) begin
            tv[n] = longint'($signed(TBL[i][32:1]));
            send(TBL[i][32:1], n == 0, TBL[i][0]);
            n++;
            if (TBL[i][0]) begin
                run_out();
                n = 0;
            end
        end

        // R9: restart mid-gather discards earlier large samples
        send(32'd1000000, 1'b1, 1'b0);
        send(32'd5000000, 1'b0, 1'b0);
        tv[0] = 7;  send(32'd7, 1'b1, 1'b0);
        tv[1] = -8; send(-32'sd8, 1'b0, 1'b1);
        n = 2;
        run_out();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule